// File: doc/BRIEF.md
# Multi-Phase Sampling Time-to-Digital Converter

This block timestamps the rising transitions of one logic input, for example the output of a comparator that watches an analog ramp. It samples that input on four clocks of the same frequency, offset by a quarter period each. The timing resolution is therefore a quarter of the clock period, while every register still runs at the base clock rate. With a 360 MHz base clock the effective rate is 1.44 GHz and one step is about 0.69 ns.

Each sample moves hop by hop through the later phases until it reaches the phase-0 domain. There a full cycle of four samples becomes one aligned word. The last sample of the previous cycle is kept, so the word can be scanned for the earliest low-to-high step, including a step across the cycle boundary. The position of that step is a 2-bit fine code. It is joined below a free-running coarse cycle count, and the result leaves with a one-cycle valid strobe. The phase clocks come from outside the block. Their generation and the placement of the capture flops are not handled here.

Top module: `multiphase_tdc`

## Requirements
- R1: Phase k (k = 0..3) samples `hit_in` at the rising edge of `clk_ph[k]`, k quarter periods after the phase-0 edge. A rise whose first high sample is phase k is reported with fine code k in `hit_time[1:0]`.
- R2: Call the cycle that begins at phase-0 edge n "cycle n". A hit in cycle n raises `hit_valid` for exactly one cycle, visible right after phase-0 edge n+2. No other cycle shows it.
- R3: Falling transitions and steady high or low input produce no hit.
- R4: A rise between the phase-3 sample of one cycle and the phase-0 sample of the next is reported in the later cycle with fine code 0.
- R5: At most one hit is reported per cycle. When several rises fall within one cycle, only the earliest is reported.
- R6: `hit_time` equals (4*n + k) modulo 2^(COARSE_W+2). Here n counts from 0 at the first phase-0 edge with `rst_n` sampled high, so the coarse count sits in the upper bits and wraps.
- R7: While `rst_n` is sampled low, `hit_valid` and `hit_time` read 0. The coarse count restarts from 0 after release, and input seen before or during reset yields no hit afterwards.
- R8: A high pulse that covers only one sample (one quarter period) is still reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ph | input | NUM_PHASES | Phase clocks; bit k lags bit 0 by k quarter periods; bit 0 clocks all outputs |
| rst_n | input | 1 | Synchronous active-low reset, sampled on every phase clock |
| hit_in | input | 1 | Asynchronous logic signal to be timestamped |
| hit_valid | output | 1 | One-cycle strobe marking a new timestamp |
| hit_time | output | COARSE_W+2 | Timestamp in quarter periods: coarse count above fine code |

## Verification
The bench plays every 8-quarter input pattern that spans two cycles, starting from a low input. This covers single-sample pulses, rises exactly at each phase, steps that cross from phase 3 into the next phase 0, and cycles with two separate rises. A design that forgot the carried phase-3 sample would miss boundary rises or report a steady high as new. One with the wrong priority would report the later of two rises. One that slipped a staging hop would shift the fine code or the output cycle. The coarse width is kept small so the timestamp wraps many times during the sweep and the pipeline-latency correction is checked across the wrap. A reset asserted while the input is high must leave no stale hit behind and must restart the count.

// File: rtl/mtdc_pkg.sv
// Shared constants of the multi-phase TDC.
// Assumes the phase count is a power of two so fine and coarse concatenate.
package mtdc_pkg;
    // Phase-0 edges between the end of a sample cycle and its result register.
    localparam int PIPE_LAT = 2;
endpackage

// File: rtl/mtdc_phase_capture.sv
// Samples the input on every phase clock and walks each sample through the
// later phases into the phase-0 domain, so that one aligned word holds the
// samples of one whole cycle. Assumes clk_ph[k] lags clk_ph[0] by k/N period.
module mtdc_phase_capture #(
    parameter int NUM_PHASES = 4
) (
    input  logic [NUM_PHASES-1:0] clk_ph,
    input  logic                  rst_n,
    input  logic                  hit_in,
    output logic [NUM_PHASES-1:0] samples_o
);
    logic [NUM_PHASES-1:0] lane_tail;

    for (genvar k = 0; k < NUM_PHASES; k++) begin : g_lane
        for (genvar j = k; j < NUM_PHASES; j++) begin : g_hop
            logic q;
            if (j == k) begin : g_cap
                // Capture the raw input on this lane's own phase.
                always_ff @(posedge clk_ph[j]) begin
                    if (!rst_n) q <= 1'b0;
                    else        q <= hit_in;
                end
            end else begin : g_move
                // Hand the sample one phase later, towards phase 0.
                always_ff @(posedge clk_ph[j]) begin
                    if (!rst_n) q <= 1'b0;
                    else        q <= g_hop[j-1].q;
                end
            end
        end
        assign lane_tail[k] = g_hop[NUM_PHASES-1].q;
    end

    // Land all lanes together in the phase-0 domain.
    always_ff @(posedge clk_ph[0]) begin
        if (!rst_n) samples_o <= '0;
        else        samples_o <= lane_tail;
    end
endmodule

// File: rtl/mtdc_coarse_counter.sv
// Free-running cycle counter in the phase-0 domain; wraps at its width.
// Assumes rst_n is synchronous to clk.
module mtdc_coarse_counter #(
    parameter int COARSE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [COARSE_W-1:0] count_o
);
    // Count phase-0 cycles since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) count_o <= '0;
        else        count_o <= count_o + COARSE_W'(1);
    end

    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> count_o == $past(count_o) + COARSE_W'(1));

    a_r7_count_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> count_o == '0);
endmodule

// File: rtl/mtdc_edge_encoder.sv
// Finds the earliest low-to-high step in the aligned samples, using the last
// sample of the previous cycle as predecessor of phase 0, and registers the
// timestamp {coarse, fine}. Assumes coarse_i is already latency-corrected.
module mtdc_edge_encoder #(
    parameter int NUM_PHASES = 4,
    parameter int COARSE_W   = 12,
    localparam int FINE_W    = $clog2(NUM_PHASES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PHASES-1:0]      samples_i,
    input  logic [COARSE_W-1:0]        coarse_i,
    output logic                       hit_valid_o,
    output logic [COARSE_W+FINE_W-1:0] hit_time_o
);
    logic                  prev_last;
    logic [NUM_PHASES-1:0] rise;
    logic                  found;
    logic [FINE_W-1:0]     first;

    // Mark every sample that is high while its predecessor was low.
    always_comb rise = samples_i & ~{samples_i[NUM_PHASES-2:0], prev_last};

    // Priority-pick the earliest rise.
    always_comb begin
        found = 1'b0;
        first = '0;
        for (int i = NUM_PHASES - 1; i >= 0; i--) begin
            if (rise[i]) begin
                found = 1'b1;
                first = FINE_W'(i);
            end
        end
    end

    // Keep the latest sample for the next cycle's boundary check.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_last <= 1'b0;
        else        prev_last <= samples_i[NUM_PHASES-1];
    end

    // Register the strobe and, on a hit, the timestamp.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_valid_o <= 1'b0;
            hit_time_o  <= '0;
        end else begin
            hit_valid_o <= found;
            if (found) hit_time_o <= {coarse_i, first};
        end
    end

    a_r3_quiet_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        (samples_i == '0) |=> !hit_valid_o);

    a_r3_steady_high_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_last && (&samples_i)) |=> !hit_valid_o);

    a_r4_boundary_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!prev_last && samples_i[0]) |=> (hit_valid_o && hit_time_o[FINE_W-1:0] == '0));

    a_r5_valid_has_input: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid_o |-> $past(samples_i != '0));
endmodule

// File: rtl/multiphase_tdc.sv
// Multi-phase sampling TDC top: capture, alignment, edge encoding and coarse
// count. Assumes NUM_PHASES is a power of two and rst_n is phase-0 synchronous.
module multiphase_tdc #(
    parameter int NUM_PHASES = 4,
    parameter int COARSE_W   = 12
) (
    input  logic [NUM_PHASES-1:0]                     clk_ph,
    input  logic                                      rst_n,
    input  logic                                      hit_in,
    output logic                                      hit_valid,
    output logic [COARSE_W+$clog2(NUM_PHASES)-1:0]    hit_time
);
    import mtdc_pkg::*;

    logic [NUM_PHASES-1:0] samples;
    logic [COARSE_W-1:0]   count;
    logic [COARSE_W-1:0]   coarse_of_sample;

    mtdc_phase_capture #(.NUM_PHASES(NUM_PHASES)) capture_i (
        .clk_ph    (clk_ph),
        .rst_n     (rst_n),
        .hit_in    (hit_in),
        .samples_o (samples)
    );

    mtdc_coarse_counter #(.COARSE_W(COARSE_W)) counter_i (
        .clk     (clk_ph[0]),
        .rst_n   (rst_n),
        .count_o (count)
    );

    // Refer the running count back to the cycle the samples were taken in.
    always_comb coarse_of_sample = count - COARSE_W'(PIPE_LAT);

    mtdc_edge_encoder #(.NUM_PHASES(NUM_PHASES), .COARSE_W(COARSE_W)) encoder_i (
        .clk         (clk_ph[0]),
        .rst_n       (rst_n),
        .samples_i   (samples),
        .coarse_i    (coarse_of_sample),
        .hit_valid_o (hit_valid),
        .hit_time_o  (hit_time)
    );
endmodule

// File: tb/multiphase_tdc_tb_top.sv
`timescale 1ns/100ps
module multiphase_tdc_tb_top;
    localparam int NPH = 4;
    localparam int CW  = 5;
    localparam int TSW = CW + 2;

    logic [NPH-1:0] clk_ph = '0;
    logic           rst_n  = 1'b0;
    logic           hit_in = 1'b0;
    logic           hit_valid;
    logic [TSW-1:0] hit_time;
    int checks = 0;
    int errors = 0;
    int cyc_cnt = 0;

    multiphase_tdc #(.NUM_PHASES(NPH), .COARSE_W(CW)) dut_i (
        .clk_ph(clk_ph), .rst_n(rst_n), .hit_in(hit_in),
        .hit_valid(hit_valid), .hit_time(hit_time)
    );

    // 50 MHz phase clocks, each 5 ns behind the previous one.
    initial forever begin
        for (int s = 0; s < 8; s++) begin
            for (int k = 0; k < NPH; k++) clk_ph[k] = (((s + 8 - 2 * k) % 8) < 4);
            #2.5;
        end
    end

    // Bench cycle index: value n+1 just after phase-0 edge n.
    always @(posedge clk_ph[0]) cyc_cnt <= rst_n ? cyc_cnt + 1 : 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Play 8 quarter samples starting at phase 0 of the next cycle; check outputs.
    task automatic run_pat(input logic [7:0] pat);
        int n;
        bit ev[3];
        int et[3];
        string tg[3];
        @(posedge clk_ph[0]);
        #1;
        n = cyc_cnt;   // edge index e = cyc_cnt-1, pattern cycle n = e+1
        for (int c = 0; c < 3; c++) begin
            int nrise = 0;
            bit fall = 0;
            ev[c] = 0; et[c] = 0; tg[c] = "R2";
            for (int i = 0; i < 4; i++) begin
                int q = 4 * c + i;
                bit cur = (q < 8) ? pat[q] : 1'b0;
                bit bef = (q == 0) ? 1'b0 : ((q - 1 < 8) ? pat[q-1] : 1'b0);
                bit nxt = (q + 1 < 8) ? pat[q+1] : 1'b0;
                if (!cur && bef) fall = 1;
                if (cur && !bef) begin
                    nrise++;
                    if (!ev[c]) begin
                        ev[c] = 1;
                        et[c] = (4 * (n + c) + i) % (1 << TSW);
                        if (i == 0 && c == 1) tg[c] = "R4";
                        else if (!nxt) tg[c] = "R8";
                        else tg[c] = "R1/R6";
                    end
                end
            end
            if (ev[c] && nrise > 1) tg[c] = "R5";
            if (!ev[c] && fall) tg[c] = "R3";
        end
        fork
            begin
                #16.5;
                for (int q = 0; q < 8; q++) begin
                    hit_in = pat[q];
                    #5;
                end
                hit_in = 1'b0;
            end
            begin
                repeat (3) @(posedge clk_ph[0]);
                for (int c = 0; c < 3; c++) begin
                    #2.5;
                    check(hit_valid == ev[c], tg[c], "hit_valid", int'(hit_valid), int'(ev[c]));
                    if (ev[c] && hit_valid)
                        check(hit_time == TSW'(et[c]), tg[c], "hit_time", int'(hit_time), et[c]);
                    if (c < 2) @(posedge clk_ph[0]);
                end
            end
        join
    endtask

    initial begin
        // R7: outputs idle during reset.
        repeat (3) @(posedge clk_ph[0]);
        #2.5;
        check(hit_valid == 1'b0, "R7", "hit_valid in reset", int'(hit_valid), 0);
        check(hit_time == '0, "R7", "hit_time in reset", int'(hit_time), 0);
        @(posedge clk_ph[0]);
        #1 rst_n = 1'b1;

        // R1..R6, R8: every two-cycle pattern from a low start.
        for (int p = 0; p < 256; p++) run_pat(8'(p));

        // R7: reset while the input is high leaves no stale hit.
        @(posedge clk_ph[0]);
        #1 hit_in = 1'b1;
        #5 rst_n = 1'b0;
        for (int c = 0; c < 3; c++) begin
            @(posedge clk_ph[0]);
            #2.5;
            check(hit_valid == 1'b0, "R7", "hit_valid under reset", int'(hit_valid), 0);
        end
        hit_in = 1'b0;
        @(posedge clk_ph[0]);
        #1 rst_n = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(posedge clk_ph[0]);
            #2.5;
            check(hit_valid == 1'b0, "R7", "hit_valid after release", int'(hit_valid), 0);
        end
        // R7: coarse count restarted; pattern timestamp uses the new origin.
        run_pat(8'b0000_0010);
        run_pat(8'b1000_0000);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule